// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block is the processor-facing register access stage for a two-channel serial controller. It takes a simple synchronous bus (chip selects, a four-bit address, separate write and read strobes, byte data) and sends each access to one of two identical per-channel register banks. Each bank holds a line control byte, a pair of divisor latch bytes and a scratch byte. Line shifting, FIFOs, interrupts, modem lines and baud generation live elsewhere.

A static mode input picks between two chip-select schemes. In dual-select mode each channel has its own active-low select, and asserting both lets one write load the same register in both channels at once, which is useful at start-up. In address-select mode the first select acts as the only chip select and address bit 3 picks the channel. When both divisor latches of a channel hold zero and the divisor access bit is set, the divisor offsets return a fixed device code and revision code. A reset qualifier only starts an internal reset after the raw reset input has been low for a set number of clocks, so short glitches on it are ignored.

Top module: `dual_uart_hostif`

## Requirements
- R1: In dual-select mode (`bus_mode_i`=1), `sel_a_n` low alone selects channel A, `sel_b_n` low alone selects channel B, and both high selects nothing, so a read gives `rvalid_o`=0 and `rdata_o`=0x00.
- R2: In dual-select mode with both selects low, a write loads the addressed register in both channels on the same edge, and a read gives `rvalid_o`=0 and `rdata_o`=0x00.
- R3: In address-select mode (`bus_mode_i`=0), `sel_a_n` is the only chip select. `addr_i[3]`=0 picks channel A and 1 picks channel B. `sel_b_n` has no effect.
- R4: In dual-select mode, `addr_i[3]` has no effect on which channel is selected.
- R5: The bus mode is taken from `bus_mode_i` only while the internal reset is active. Changing `bus_mode_i` later does not change the decode.
- R6: The divisor access bit is bit 7 of the line control register. While it is clear, offsets 0 and 1 read 0x00 and writes to them are ignored. While it is set, offset 0 is divisor low and offset 1 is divisor high.
- R7: While the divisor access bit is set and both divisor bytes are 0x00, offset 1 reads the device code 0x0A and offset 0 reads the revision code 0x01.
- R8: Offset 7 is the scratch byte and reads back the last value written to it.
- R9: The internal reset sets both channels to line control 0x00, scratch 0xFF, divisor low 0x01 and divisor high 0x00.
- R10: The internal reset starts only after `rst_in_n` has been sampled low on `RST_HOLD_CYC` (default 6) consecutive rising edges. A shorter low pulse leaves all register contents unchanged.
- R11: A read strobe with exactly one channel selected sets `rvalid_o`=1 and `rdata_o` to the addressed value on the next rising edge. Offsets 2, 4, 5 and 6 read 0x00. At all other times `rvalid_o`=0 and `rdata_o`=0x00.
- R12: The line control register at offset 3 reads back all eight bits last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_in_n | input | 1 | Raw active-low reset, qualified internally |
| bus_mode_i | input | 1 | 1 = dual-select decode, 0 = address-select decode |
| sel_a_n | input | 1 | Channel A select (dual mode) or chip select (address mode), active low |
| sel_b_n | input | 1 | Channel B select, active low, used only in dual mode |
| addr_i | input | 4 | Bits 2:0 register offset, bit 3 channel pick in address mode |
| wr_en_i | input | 1 | Write strobe, acts on the rising edge |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rvalid_o | output | 1 | High for one cycle after an accepted read |

## Verification
A write changes register state on the rising edge where the strobe is sampled. Read data and its valid flag are registered, so they appear one edge after the read strobe. The internal reset takes hold on the edge after the `RST_HOLD_CYC`-th consecutive low sample and releases on the first high sample. The bench model follows these same edge counts and is compared at each falling edge. Directed reads also drive the strobe on a falling edge and check the outputs at the next falling edge, so only the registered result is compared.

// File: rtl/hostif_pkg.sv
// Package: shared constants and the bus mode type for the host front end.
// Assumes 8-bit registers and a 3-bit register offset.
package hostif_pkg;

    typedef enum logic {
        MODE_ADDR_SEL = 1'b0,
        MODE_DUAL_SEL = 1'b1
    } bus_mode_e;

    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_DIV_LO  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_DIV_HI  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_LINE    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_SCRATCH = 3'd7;

    localparam int DIV_ACCESS_BIT = 7;

    localparam logic [DATA_W-1:0] DEV_CODE = 8'h0A;
    localparam logic [DATA_W-1:0] REV_CODE = 8'h01;

    localparam logic [DATA_W-1:0] RST_LINE    = 8'h00;
    localparam logic [DATA_W-1:0] RST_SCRATCH = 8'hFF;
    localparam logic [DATA_W-1:0] RST_DIV_LO  = 8'h01;
    localparam logic [DATA_W-1:0] RST_DIV_HI  = 8'h00;

endpackage

// File: rtl/hostif_rst_qual.sv
// Module: reset qualifier. It drives core_rst_n low only after rst_in_n has
// been sampled low on HOLD_CYC consecutive edges, and releases it on the
// first high sample. Assumes the FPGA-style power-up values below and starts
// in reset.
module hostif_rst_qual #(
    parameter int HOLD_CYC = 6
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic core_rst_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] low_cnt = '0;
    logic          rst_q   = 1'b0;

    // Count consecutive low samples, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (rst_in_n)
            low_cnt <= '0;
        else if (low_cnt != CW'(HOLD_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    // Enter reset on the edge that completes the hold window.
    always_ff @(posedge clk) begin
        rst_q <= !(!rst_in_n && (low_cnt >= CW'(HOLD_CYC - 1)));
    end

    assign core_rst_n = rst_q;

    AST_RST_NEEDS_LOW: assert property (@(posedge clk)
        $fell(core_rst_n) |-> !rst_in_n); // R10

endmodule

// File: rtl/hostif_cs_decode.sv
// Module: chip-select decode. Turns the two active-low selects and address
// bit 3 into a per-channel select vector for the latched bus mode.
// Assumes mode is stable outside reset.
module hostif_cs_decode
    import hostif_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              addr_hi,
    output logic [NUM_CH-1:0] ch_sel
);
    // Select channels according to the active decode scheme.
    always_comb begin
        ch_sel = '0;
        if (mode == MODE_DUAL_SEL) begin
            ch_sel[0] = !sel_a_n;
            ch_sel[1] = !sel_b_n;
        end else begin
            ch_sel[0] = !sel_a_n && !addr_hi;
            ch_sel[1] = !sel_a_n &&  addr_hi;
        end
    end

    AST_ADDR_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ADDR_SEL) |-> $onehot0(ch_sel)); // R3

endmodule

// File: rtl/hostif_regbank.sv
// Module: one channel's register bank (line control, divisor pair, scratch).
// It writes on wr_hit and gives a combinational read value for the offset.
// Assumes rst_n is the qualified synchronous reset.
module hostif_regbank
    import hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] line_q, scratch_q, div_lo_q, div_hi_q;
    logic              div_access;
    logic              id_active;

    assign div_access = line_q[DIV_ACCESS_BIT];
    assign id_active  = (div_lo_q == '0) && (div_hi_q == '0);

    // Register updates: reset defaults, otherwise decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= RST_LINE;
            scratch_q <= RST_SCRATCH;
            div_lo_q  <= RST_DIV_LO;
            div_hi_q  <= RST_DIV_HI;
        end else if (wr_hit) begin
            case (offset)
                OFS_LINE:    line_q    <= wdata;
                OFS_SCRATCH: scratch_q <= wdata;
                OFS_DIV_LO:  if (div_access) div_lo_q <= wdata;
                OFS_DIV_HI:  if (div_access) div_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux, with the identification codes over zeroed divisors.
    always_comb begin
        rd_val = '0;
        case (offset)
            OFS_LINE:    rd_val = line_q;
            OFS_SCRATCH: rd_val = scratch_q;
            OFS_DIV_LO:  if (div_access) rd_val = id_active ? REV_CODE : div_lo_q;
            OFS_DIV_HI:  if (div_access) rd_val = id_active ? DEV_CODE : div_hi_q;
            default:     rd_val = '0;
        endcase
    end

    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !div_access |=> ($stable(div_lo_q) && $stable(div_hi_q))); // R6
    AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit || offset != OFS_SCRATCH) |=> $stable(scratch_q)); // R8
    AST_RESET_SCRATCH: assert property (@(posedge clk)
        !rst_n |=> (scratch_q == RST_SCRATCH)); // R9

endmodule

// File: rtl/dual_uart_hostif.sv
// Module: top of the two-channel host register front end. It qualifies reset,
// latches the bus mode during reset, decodes the selects, holds one register
// bank per channel and registers the read result.
// Assumes synchronous strobes sampled on the rising edge of clk.
module dual_uart_hostif
    import hostif_pkg::*;
#(
    parameter int RST_HOLD_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_in_n,
    input  logic              bus_mode_i,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic [3:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int NUM_CH = 2;

    logic                          core_rst_n;
    bus_mode_e                     mode_q;
    logic [NUM_CH-1:0]             ch_sel;
    logic [NUM_CH-1:0][DATA_W-1:0] bank_rd;
    logic                          one_sel;

    hostif_rst_qual #(.HOLD_CYC(RST_HOLD_CYC)) u_rst_qual (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .core_rst_n (core_rst_n)
    );

    // Capture the bus mode only while the internal reset is active.
    always_ff @(posedge clk) begin
        if (!core_rst_n)
            mode_q <= bus_mode_e'(bus_mode_i);
    end

    hostif_cs_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .mode    (mode_q),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .addr_hi (addr_i[3]),
        .ch_sel  (ch_sel)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
        hostif_regbank u_bank (
            .clk    (clk),
            .rst_n  (core_rst_n),
            .wr_hit (wr_en_i && ch_sel[ch]),
            .offset (addr_i[OFS_W-1:0]),
            .wdata  (wdata_i),
            .rd_val (bank_rd[ch])
        );
    end

    assign one_sel = $onehot(ch_sel);

    // Register the read result when exactly one channel is addressed.
    always_ff @(posedge clk) begin
        if (!core_rst_n || !(rd_en_i && one_sel)) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rdata_o  <= ch_sel[0] ? bank_rd[0] : bank_rd[1];
            rvalid_o <= 1'b1;
        end
    end

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!core_rst_n)
        rvalid_o |-> $past(rd_en_i)); // R11
    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!core_rst_n)
        !rvalid_o |-> (rdata_o == '0)); // R11
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!core_rst_n)
        $past(core_rst_n) |-> $stable(mode_q)); // R5

endmodule

// File: tb/dual_uart_hostif_bench.sv
module dual_uart_hostif_bench;
    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_in_n = 1'b0;
    logic       bus_mode = 1'b1;
    logic       sel_a_n = 1'b1, sel_b_n = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_o;
    logic       rvalid_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_uart_hostif #(.RST_HOLD_CYC(HOLD)) u_dual_uart_hostif (
        .clk(clk), .rst_in_n(rst_in_n), .bus_mode_i(bus_mode),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    // Behavioural reference model, advanced on each rising edge.
    int m_line[2], m_scr[2], m_dlo[2], m_dhi[2];
    int m_cnt = 0;
    bit m_in_rst = 1;
    bit m_mode = 1;
    int exp_rd = 0;
    bit exp_rv = 0;
    bit started = 0;

    function automatic int m_read(int c, int ofs);
        bit acc = m_line[c][7];
        bit zero = (m_dlo[c] == 0) && (m_dhi[c] == 0);
        case (ofs)
            0: return acc ? (zero ? 8'h01 : m_dlo[c]) : 0;
            1: return acc ? (zero ? 8'h0A : m_dhi[c]) : 0;
            3: return m_line[c];
            7: return m_scr[c];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit sa, sb;
        int ofs;
        started = 1;
        ofs = int'(addr[2:0]);
        if (m_in_rst) begin
            for (int c = 0; c < 2; c++) begin
                m_line[c] = 0; m_scr[c] = 8'hFF; m_dlo[c] = 1; m_dhi[c] = 0;
            end
            m_mode = bus_mode;
            exp_rd = 0; exp_rv = 0;
        end else begin
            if (m_mode) begin sa = !sel_a_n; sb = !sel_b_n; end
            else begin sa = !sel_a_n && !addr[3]; sb = !sel_a_n && addr[3]; end
            if (rd_en && (sa != sb)) begin exp_rd = m_read(sa ? 0 : 1, ofs); exp_rv = 1; end
            else begin exp_rd = 0; exp_rv = 0; end
            if (wr_en) begin
                for (int c = 0; c < 2; c++) begin
                    if ((c == 0 && sa) || (c == 1 && sb)) begin
                        case (ofs)
                            3: m_line[c] = wdata;
                            7: m_scr[c] = wdata;
                            0: if (m_line[c][7]) m_dlo[c] = wdata;
                            1: if (m_line[c][7]) m_dhi[c] = wdata;
                            default: ;
                        endcase
                    end
                end
            end
        end
        if (!rst_in_n) m_cnt++; else m_cnt = 0;
        m_in_rst = (m_cnt >= HOLD);
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (rdata_o !== 8'(exp_rd) || rvalid_o !== exp_rv) begin
                n_bad++;
                $display("FAIL R11 model: got data %02h valid %0b, expected data %02h valid %0b",
                         rdata_o, rvalid_o, 8'(exp_rd), exp_rv);
            end
        end
    end

    task automatic idle();
        sel_a_n = 1; sel_b_n = 1; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic an, input logic bn, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_a_n = an; sel_b_n = bn; addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic an, input logic bn, input logic [3:0] a,
                      input logic [7:0] ed, input logic ev, input string tag);
        @(negedge clk);
        sel_a_n = an; sel_b_n = bn; addr = a; rd_en = 1;
        @(negedge clk);
        n_chk++;
        if (rdata_o !== ed || rvalid_o !== ev) begin
            n_bad++;
            $display("FAIL %s: got data %02h valid %0b, expected data %02h valid %0b",
                     tag, rdata_o, rvalid_o, ed, ev);
        end
        idle();
    endtask

    task automatic rst_pulse(input int n);
        @(negedge clk);
        rst_in_n = 0;
        repeat (n) @(negedge clk);
        rst_in_n = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_in_n = 1;
        repeat (2) @(negedge clk);
        // R9 defaults
        rd(0, 1, 4'd3, 8'h00, 1, "R9");
        rd(0, 1, 4'd7, 8'hFF, 1, "R9");
        rd(1, 0, 4'd7, 8'hFF, 1, "R9");
        wr(0, 1, 4'd3, 8'h80);
        rd(0, 1, 4'd0, 8'h01, 1, "R9");
        rd(0, 1, 4'd1, 8'h00, 1, "R9");
        // R7 identification over zeroed divisors
        wr(0, 1, 4'd0, 8'h00);
        rd(0, 1, 4'd1, 8'h0A, 1, "R7");
        rd(0, 1, 4'd0, 8'h01, 1, "R7");
        wr(0, 1, 4'd1, 8'h05);
        rd(0, 1, 4'd1, 8'h05, 1, "R7");
        rd(0, 1, 4'd0, 8'h00, 1, "R7");
        // R6 divisor access gating
        wr(0, 1, 4'd3, 8'h03);
        rd(0, 1, 4'd0, 8'h00, 1, "R6");
        rd(0, 1, 4'd1, 8'h00, 1, "R6");
        wr(0, 1, 4'd1, 8'h77);
        wr(0, 1, 4'd3, 8'h83);
        rd(0, 1, 4'd1, 8'h05, 1, "R6");
        // R12 line control readback
        rd(0, 1, 4'd3, 8'h83, 1, "R12");
        wr(0, 1, 4'd3, 8'h5B);
        rd(0, 1, 4'd3, 8'h5B, 1, "R12");
        // R1 single selects
        wr(1, 0, 4'd7, 8'h5A);
        rd(1, 0, 4'd7, 8'h5A, 1, "R1");
        rd(0, 1, 4'd7, 8'hFF, 1, "R1");
        rd(1, 1, 4'd7, 8'h00, 0, "R1");
        // R2 broadcast write, blocked dual read
        wr(0, 0, 4'd7, 8'h3C);
        rd(0, 1, 4'd7, 8'h3C, 1, "R2");
        rd(1, 0, 4'd7, 8'h3C, 1, "R2");
        rd(0, 0, 4'd7, 8'h00, 0, "R2");
        // R4 address bit 3 ignored in dual mode
        wr(0, 1, 4'd15, 8'h11);
        rd(0, 1, 4'd7, 8'h11, 1, "R4");
        rd(1, 0, 4'd15, 8'h3C, 1, "R4");
        // R11 unmapped offsets
        rd(0, 1, 4'd2, 8'h00, 1, "R11");
        rd(1, 0, 4'd5, 8'h00, 1, "R11");
        // R8 scratch
        wr(1, 0, 4'd7, 8'hA5);
        rd(1, 0, 4'd7, 8'hA5, 1, "R8");
        // R10 short pulse ignored
        rst_pulse(3);
        rd(1, 0, 4'd7, 8'hA5, 1, "R10");
        rd(0, 1, 4'd3, 8'h5B, 1, "R10");
        // R5 mode change without reset has no effect
        bus_mode = 0;
        rd(0, 1, 4'd15, 8'h11, 1, "R5");
        rd(1, 0, 4'd7, 8'hA5, 1, "R5");
        // Full reset into address-select mode
        rst_pulse(8);
        rd(0, 1, 4'd7, 8'hFF, 1, "R9");
        wr(0, 1, 4'd15, 8'h66);
        rd(0, 1, 4'd15, 8'h66, 1, "R3");
        rd(0, 1, 4'd7, 8'hFF, 1, "R3");
        rd(1, 0, 4'd7, 8'h00, 0, "R3");
        rd(0, 0, 4'd7, 8'hFF, 1, "R3");
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule